// File: doc/BRIEF.md
# Serial Digit Shift-and-Add Normalizer

The block takes a stream of wide, overlapping convolution digits and turns it into an ordinary binary word. Digit k of a stream carries an implicit weight of 2^k. Digits arrive one per cycle, lowest weight first. Each digit is added into a small running residue. The lowest bit of that sum is retired as result bit k, and the rest is shifted right. Carries therefore move forward one bit position per cycle, and no wide adder is needed.

After the digit flagged as last, the block keeps shifting zeros into the residue until all 32 result bit positions are filled. It then presents the word for one cycle. When the accumulate mode is selected for a stream, the finished word is also added into a 32-bit running total. This lets a sequence of scalar-vector partial products be summed element by element. The analog-to-digital step that produces the digits lies outside the block.

Top module: `serial_digit_normalizer`

## Requirements
- R1: A completed result equals the sum of digit_k·2^k over the accepted digits of the stream, taken modulo 2^32. k counts accepted digits from 0 in arrival order.
- R2: A digit is accepted on each rising edge where digit_valid_i is high and busy_o is low. Cycles with digit_valid_i low neither advance nor disturb the stream.
- R3: Once the digit with digit_last_i high is accepted, busy_o rises and the block produces one result bit position per cycle until 32 positions exist. result_valid_o is then high for exactly one cycle and busy_o is low. For a gap-free stream whose first digit is accepted on edge e, result_valid_o is high in the cycle after edge e+31.
- R4: While busy_o is high, digit_valid_i, digit_i and digit_last_i have no effect on the result.
- R5: A stream that reaches 32 accepted digits is closed at once, even when digit_last_i is low.
- R6: Streams of full-scale digits (all ones, DIGIT_W bits) give exact results with no lost carry.
- R7: While rst_ni is low, result_valid_o, busy_o and acc_o are 0.
- R8: acc_en_i is sampled with the first digit of a stream. If it was high, acc_o becomes acc_o + result (mod 2^32) on the same edge that raises result_valid_o.
- R9: For a stream whose first digit saw acc_en_i low, acc_o is left unchanged by its completion.
- R10: acc_clear_i high on an edge sets acc_o to 0. If an accumulate-mode result completes on that same edge, acc_o takes exactly that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| digit_i | input | DIGIT_W | Unsigned convolution digit |
| digit_valid_i | input | 1 | Digit present this cycle |
| digit_last_i | input | 1 | Marks the final digit of a stream |
| acc_en_i | input | 1 | Accumulate mode for the stream, sampled with its first digit |
| acc_clear_i | input | 1 | Synchronous clear of the accumulator |
| busy_o | output | 1 | Flushing; input digits are ignored |
| result_o | output | RES_W | Last completed binary word |
| result_valid_o | output | 1 | One-cycle pulse when result_o is updated |
| acc_o | output | RES_W | Running total of accumulate-mode results |

## Verification
The hardest case to reach is a clear of the accumulator that lands on the same edge as an accumulate-mode completion. To get there, gap-free streams are driven with acc_clear_i raised on the 32nd driven cycle. The stimulus also covers streams closed by the 32-digit limit rather than by the last flag. It offers junk digits throughout every flush. Finally, it runs full-scale digit streams, so that the residue sits at its upper bound for many cycles.

// File: rtl/sdn_pkg.sv
package sdn_pkg;
  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_FLUSH   = 1'b1
  } sdn_state_e;
endpackage

// File: rtl/sdn_residue.sv
module sdn_residue #(
  parameter int unsigned DIGIT_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               clear_i,
  input  logic [DIGIT_W-1:0] digit_i,
  output logic               bit_o
);
  localparam int unsigned SUM_W = DIGIT_W + 1;

  // residue stays <= 2^DIGIT_W-1, so the sum fits in DIGIT_W+1 bits
  logic [DIGIT_W-1:0] residue_q;
  logic [SUM_W-1:0]   sum_w;

  assign sum_w = {1'b0, residue_q} + {1'b0, digit_i};
  assign bit_o = sum_w[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      residue_q <= '0;
    else if (clear_i) residue_q <= '0;
    else if (step_i)  residue_q <= sum_w[SUM_W-1:1];
  end
endmodule

// File: rtl/sdn_collector.sv
module sdn_collector #(
  parameter int unsigned RES_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             load_i,
  input  logic             bit_i,
  output logic [RES_W-1:0] word_next_o,
  output logic [RES_W-1:0] result_o
);
  logic [RES_W-1:0] word_q;
  logic [RES_W-1:0] result_q;

  // bits enter at the top; after RES_W shifts the first lands at bit 0
  assign word_next_o = {bit_i, word_q[RES_W-1:1]};
  assign result_o    = result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (shift_i) word_q <= word_next_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     result_q <= '0;
    else if (load_i) result_q <= word_next_o;
  end
endmodule

// File: rtl/sdn_ctrl.sv
module sdn_ctrl
  import sdn_pkg::*;
#(
  parameter int unsigned RES_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     digit_valid_i,
  input  logic                     digit_last_i,
  input  logic                     acc_en_i,
  output logic                     take_o,
  output logic                     step_o,
  output logic                     done_o,
  output logic                     busy_o,
  output logic                     mode_o,
  output logic                     mode_q_o,
  output logic [$clog2(RES_W)-1:0] cnt_o
);
  localparam int unsigned CNT_W = $clog2(RES_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(RES_W - 1);

  sdn_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;

  assign busy_o   = (state_q == ST_FLUSH);
  assign take_o   = digit_valid_i && !busy_o;
  assign step_o   = take_o || busy_o;
  assign done_o   = step_o && (cnt_q == LAST_POS);
  assign mode_o   = (take_o && cnt_q == '0) ? acc_en_i : mode_q;
  assign mode_q_o = mode_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COLLECT;
      cnt_q   <= '0;
    end else if (done_o) begin
      state_q <= ST_COLLECT;
      cnt_q   <= '0;
    end else if (step_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (take_o && digit_last_i) state_q <= ST_FLUSH;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    mode_q <= 1'b0;
    else if (take_o && cnt_q == '0) mode_q <= acc_en_i;
  end
endmodule

// File: rtl/sdn_acc.sv
module sdn_acc #(
  parameter int unsigned RES_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_i,
  input  logic             clear_i,
  input  logic [RES_W-1:0] value_i,
  output logic [RES_W-1:0] acc_o
);
  logic [RES_W-1:0] acc_q;
  assign acc_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= add_i ? value_i : '0;
    else if (add_i)   acc_q <= acc_q + value_i;
  end
endmodule

// File: rtl/serial_digit_normalizer.sv
module serial_digit_normalizer #(
  parameter int unsigned DIGIT_W = 9,
  parameter int unsigned RES_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic               digit_valid_i,
  input  logic               digit_last_i,
  input  logic               acc_en_i,
  input  logic               acc_clear_i,
  output logic               busy_o,
  output logic [RES_W-1:0]   result_o,
  output logic               result_valid_o,
  output logic [RES_W-1:0]   acc_o
);
  localparam int unsigned CNT_W = $clog2(RES_W);

  logic               take_w, step_w, done_w, mode_w, mode_q_w, bit_w;
  logic [CNT_W-1:0]   cnt_w;
  logic [DIGIT_W-1:0] digit_eff_w;
  logic [RES_W-1:0]   word_next_w;
  logic               result_valid_q;

  sdn_ctrl #(.RES_W(RES_W)) i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .digit_valid_i (digit_valid_i),
    .digit_last_i  (digit_last_i),
    .acc_en_i      (acc_en_i),
    .take_o        (take_w),
    .step_o        (step_w),
    .done_o        (done_w),
    .busy_o        (busy_o),
    .mode_o        (mode_w),
    .mode_q_o      (mode_q_w),
    .cnt_o         (cnt_w)
  );

  // flush cycles feed zero digits
  assign digit_eff_w = take_w ? digit_i : '0;

  sdn_residue #(.DIGIT_W(DIGIT_W)) i_residue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_w),
    .clear_i (done_w),
    .digit_i (digit_eff_w),
    .bit_o   (bit_w)
  );

  sdn_collector #(.RES_W(RES_W)) i_collector (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_i     (step_w),
    .load_i      (done_w),
    .bit_i       (bit_w),
    .word_next_o (word_next_w),
    .result_o    (result_o)
  );

  sdn_acc #(.RES_W(RES_W)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .add_i   (done_w && mode_w),
    .clear_i (acc_clear_i),
    .value_i (word_next_w),
    .acc_o   (acc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) result_valid_q <= 1'b0;
    else         result_valid_q <= done_w;
  end
  assign result_valid_o = result_valid_q;
endmodule

// File: rtl/sdn_checker.sv
module sdn_checker #(
  parameter int unsigned RES_W = 32,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             result_valid_o,
  input logic [RES_W-1:0] result_o,
  input logic [RES_W-1:0] acc_o,
  input logic             acc_clear_i,
  input logic             acc_mode,
  input logic [CNT_W-1:0] cnt
);
  // R3
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);
  // R3
  valid_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(result_valid_o && busy_o));
  // R3
  valid_cnt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> cnt == '0);
  // R9
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(acc_clear_i) && !result_valid_o) |-> $stable(acc_o));
  // R10
  acc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(acc_clear_i) && !result_valid_o) |-> acc_o == '0);
  // R8
  acc_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && acc_mode && !$past(acc_clear_i)) |-> acc_o == $past(acc_o) + result_o);
  // R10
  acc_clear_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && acc_mode && $past(acc_clear_i)) |-> acc_o == result_o);
  // R7
  reset_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !result_valid_o && acc_o == '0));
endmodule

bind serial_digit_normalizer sdn_checker #(.RES_W(RES_W), .CNT_W($clog2(RES_W))) i_sdn_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .busy_o         (busy_o),
  .result_valid_o (result_valid_o),
  .result_o       (result_o),
  .acc_o          (acc_o),
  .acc_clear_i    (acc_clear_i),
  .acc_mode       (mode_q_w),
  .cnt            (cnt_w)
);

// File: tb/test_serial_digit_normalizer.sv
module test_serial_digit_normalizer;
  localparam int DIGIT_W = 9;
  localparam int RES_W   = 32;
  localparam int L_BITS  = 16;
  localparam int NDIG    = 2 * L_BITS - 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [DIGIT_W-1:0] digit = '0;
  logic               dvalid = 1'b0, dlast = 1'b0, acc_en = 1'b0, acc_clr = 1'b0;
  logic               busy, rvalid;
  logic [RES_W-1:0]   result, acc;

  always #2 clk = ~clk;

  serial_digit_normalizer #(.DIGIT_W(DIGIT_W), .RES_W(RES_W)) i_serial_digit_normalizer (
    .clk_i(clk), .rst_ni(rst_n), .digit_i(digit), .digit_valid_i(dvalid),
    .digit_last_i(dlast), .acc_en_i(acc_en), .acc_clear_i(acc_clr),
    .busy_o(busy), .result_o(result), .result_valid_o(rvalid), .acc_o(acc)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: weighted digit sum, position count, flush flag
  int      m_pos = 0;
  bit      m_flush = 0, m_mode = 0;
  longint  m_sum = 0;
  bit      e_valid = 0, e_busy = 0;
  longint  e_res = 0, e_acc = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_flush = 0; m_mode = 0; m_sum = 0;
      e_valid = 0; e_busy = 0; e_res = 0; e_acc = 0;
    end else begin
      bit take, adv, fin;
      longint nacc;
      take = dvalid && !m_flush;
      adv  = take || m_flush;
      fin  = 0;
      if (take) begin
        if (m_pos == 0) m_mode = acc_en;
        m_sum = m_sum + (longint'(digit) << m_pos);
      end
      if (adv) begin
        if (m_pos == RES_W - 1) fin = 1;
        else begin
          m_pos++;
          if (take && dlast) m_flush = 1;
        end
      end
      nacc = acc_clr ? 0 : e_acc;
      e_valid = fin;
      if (fin) begin
        e_res = m_sum & 64'hFFFF_FFFF;
        if (m_mode) nacc = (nacc + e_res) & 64'hFFFF_FFFF;
        m_pos = 0; m_flush = 0; m_sum = 0;
      end
      e_acc = nacc;
      e_busy = m_flush;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rst_n && !finished) begin
    check(rvalid == e_valid, "R3 result_valid", rvalid, e_valid);
    check(busy == e_busy, "R4 busy", busy, e_busy);
    check(acc == e_acc[31:0], "R8/R9/R10 acc", acc, e_acc);
    if (e_valid) check(result == e_res[31:0], "R1 result", result, e_res);
  end

  // n digits; kind 1 = full scale; gap_pct idle chance; clr_at cycle index of clear
  task automatic run_stream(input int n, input bit use_last, input bit mode,
                            input int kind, input int gap_pct, input int clr_at);
    int i = 0;
    int c = 0;
    int tail = 0;
    while (tail < 36) begin
      @(negedge clk);
      acc_clr = (c == clr_at);
      if (i < n) begin
        if ($urandom_range(99) < gap_pct) begin
          dvalid = 1'b0; digit = DIGIT_W'($urandom);
        end else begin
          dvalid = 1'b1;
          digit  = (kind == 1) ? '1 : DIGIT_W'($urandom);
          dlast  = use_last && (i == n - 1);
          acc_en = (i == 0) ? mode : bit'($urandom);
          i++;
        end
      end else begin
        // R4: junk while flushing
        dvalid = busy; digit = DIGIT_W'($urandom); dlast = bit'($urandom);
        acc_en = bit'($urandom);
        tail++;
      end
      c++;
    end
    @(negedge clk);
    dvalid = 1'b0; dlast = 1'b0; acc_clr = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    check(busy == 0, "R7 busy in reset", busy, 0);
    check(rvalid == 0, "R7 valid in reset", rvalid, 0);
    check(acc == 0, "R7 acc in reset", acc, 0);
    rst_n = 1'b1;
    // R1 R2 R3 random full-length streams, with and without gaps
    for (int k = 0; k < 8; k++) run_stream(NDIG, 1, 0, 0, (k % 2) * 30, -1);
    // R6 full-scale digits
    for (int k = 0; k < 3; k++) run_stream(NDIG, 1, 0, 1, 0, -1);
    run_stream(RES_W, 1, 1, 1, 0, -1);
    // R3 short streams, single digit
    run_stream(1, 1, 0, 1, 0, -1);
    for (int k = 1; k < 12; k++) run_stream(k, 1, 1, 0, 20, -1);
    // R5 closed by length, no last flag
    run_stream(RES_W, 0, 0, 0, 0, -1);
    run_stream(RES_W, 0, 1, 1, 10, -1);
    // R8 accumulate sequence, R9 mixed modes
    for (int k = 0; k < 10; k++) run_stream(NDIG, 1, k != 3, k % 3 == 0, 0, -1);
    // R10 clear while idle, and clear coincident with completion
    run_stream(NDIG, 1, 1, 0, 0, 40);
    run_stream(NDIG, 1, 1, 0, 0, 31);
    run_stream(NDIG, 1, 1, 1, 0, -1);
    run_stream(NDIG, 1, 0, 0, 0, 31);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule